// File: doc/BRIEF.md
# I2C Master Byte Transfer Engine

This block is the data phase of an I2C master. A start condition has already been placed on the bus, and SCL has been left low. Software then writes the shared buffer register with the address-phase strobe raised. The block clocks out the 7-bit target address followed by the read/write mode bit and samples the acknowledge. After that, each further buffer write sends one data byte. In read mode, an acknowledged address starts automatic reception: bytes are clocked in with no further writes, placed in the same buffer, and answered with an acknowledge level chosen by software.

Both bus lines are open-drain. The block only produces drive-low enables and reads SDA back from the line. The SCL high and low phases each last `HALF_CYC` system clocks. Status is reported on five signals: busy, transmit-done, receive-done, NACK and overrun. The four event flags are cleared by write-one pulses. Reading the buffer empties it.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the block drives neither SCL nor SDA low, busy and all four flags are 0, and the buffer reads 0x00.
- R2: A buffer write with `addr_phase_i` high puts the byte {wdata[6:0], mode} on SDA MSB first, followed by a ninth clock with SDA released. SDA is sampled on each SCL rising edge, and SDA never changes while SCL is high.
- R3: An accepted buffer write raises `busy_o` in the next cycle. A buffer write made while busy is ignored: the buffer contents and the byte on the bus are unchanged.
- R4: A buffer write with `addr_phase_i` low sends the 8-bit value MSB first, followed by an acknowledge clock with SDA released.
- R5: At the end of the acknowledge clock of any transmitted byte, `nack_o` takes the sampled SDA level (1 = not acknowledged) and `txdone_o` is set. Unless reception follows, `busy_o` clears and SCL stays driven low.
- R6: An address byte with mode 1 that is not acknowledged starts no reception. Busy clears, and no further SCL pulses are produced.
- R7: An address byte with mode 1 that is acknowledged starts reception with no buffer write. Busy stays 1, and SDA is released during the data bits.
- R8: After the 8th received bit the byte enters the buffer and `rxdone_o` is set. In the ninth clock the master drives SDA low when `ack_ctl_i` is 0, or releases it when `ack_ctl_i` is 1. After releasing it, reception stops and busy clears.
- R9: If a received byte is ready while the buffer still holds an unread byte, `ovr_o` is set and the buffer keeps the older byte.
- R10: `rd_en_i` empties the buffer. A read in the same cycle as a receive load counts as having emptied it: the new byte is loaded and no overrun is flagged.
- R11: `clr_i` clears flags write-one style, with bit 0 = txdone, bit 1 = rxdone, bit 2 = nack and bit 3 = ovr.
- R12: Within a byte, SCL is high for exactly `HALF_CYC` clocks and low for exactly `HALF_CYC` clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Buffer write strobe |
| wdata_i | input | 8 | Buffer write data |
| addr_phase_i | input | 1 | Marks the write as the address byte |
| mode_i | input | 1 | R/W bit sent with the address (1 = read) |
| ack_ctl_i | input | 1 | Acknowledge level sent after a received byte (0 = ACK) |
| rd_en_i | input | 1 | Buffer read strobe, empties the buffer |
| clr_i | input | 4 | Write-one flag clear |
| sda_i | input | 1 | SDA line level |
| rdata_o | output | 8 | Buffer contents |
| busy_o | output | 1 | Transfer in progress |
| txdone_o | output | 1 | Transmitted byte finished |
| rxdone_o | output | 1 | Received byte loaded |
| nack_o | output | 1 | Last acknowledge sampled high |
| ovr_o | output | 1 | Receive overrun |
| scl_oe_o | output | 1 | Drive SCL low |
| sda_oe_o | output | 1 | Drive SDA low |

## Verification
Two events can fall in the same clock cycle: software reading the buffer and the receiver loading a new byte. The bench sets this up with a third received byte while the buffer still holds an unread earlier one. It counts SCL rising edges from the address byte, then places the read pulse on the exact cycle in which the high phase of the 8th bit ends. The collision is judged correct if the buffer holds the third byte and the overrun flag stays clear. Just before this, a second byte is left unread on purpose, to show that without the read the old byte stays and overrun is raised.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  localparam int BYTE_W = 8;
  localparam int FLAG_N = 4;
  localparam int SLOT_W = $clog2(BYTE_W + 1);

  localparam int FLG_TX   = 0;
  localparam int FLG_RX   = 1;
  localparam int FLG_NACK = 2;
  localparam int FLG_OVR  = 3;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_TX   = 2'd1,
    ENG_RX   = 2'd2
  } eng_st_e;
endpackage

// File: rtl/i2c_bm_sclgen.sv
module i2c_bm_sclgen #(
  parameter int HALF_CYC = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic hold_i,
  output logic scl_oe_o,
  output logic drv_o,
  output logic smp_o,
  output logic done_o
);
  localparam int CNT_W = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_CYC - 1);

  logic             high_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      high_q <= 1'b0;
      cnt_q  <= CNT_TOP;
    end else if (!run_i) begin
      high_q <= 1'b0;
      cnt_q  <= CNT_TOP;
    end else if (cnt_q == '0) begin
      high_q <= ~high_q;
      cnt_q  <= CNT_TOP;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // first low cycle: update data; first high cycle: sample; last high cycle: slot end
  assign drv_o    = run_i & ~high_q & (cnt_q == CNT_TOP);
  assign smp_o    = run_i &  high_q & (cnt_q == CNT_TOP);
  assign done_o   = run_i &  high_q & (cnt_q == '0);
  assign scl_oe_o = ~high_q & (run_i | hold_i);
endmodule

// File: rtl/i2c_bm_engine.sv
module i2c_bm_engine
  import i2c_bm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              addr_i,
  input  logic              rw_i,
  input  logic              ack_ctl_i,
  input  logic              sda_i,
  input  logic              drv_i,
  input  logic              smp_i,
  input  logic              done_i,
  output logic              run_o,
  output logic              sda_oe_o,
  output logic              tx_done_o,
  output logic              ack_lvl_o,
  output logic              rx_load_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  localparam logic [SLOT_W-1:0] ACK_SLOT  = SLOT_W'(BYTE_W);
  localparam logic [SLOT_W-1:0] LAST_DATA = SLOT_W'(BYTE_W - 1);

  eng_st_e           st_q;
  logic [BYTE_W-1:0] sh_q;
  logic [SLOT_W-1:0] slot_q;
  logic              addr_q, rw_q, sda_oe_q, bit_q, nack_tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ENG_IDLE;
      sh_q      <= '0;
      slot_q    <= '0;
      addr_q    <= 1'b0;
      rw_q      <= 1'b0;
      sda_oe_q  <= 1'b0;
      bit_q     <= 1'b0;
      nack_tx_q <= 1'b0;
    end else begin
      unique case (st_q)
        ENG_IDLE: begin
          if (start_i) begin
            sh_q     <= byte_i;
            slot_q   <= '0;
            addr_q   <= addr_i;
            rw_q     <= rw_i;
            sda_oe_q <= ~byte_i[BYTE_W-1];
            st_q     <= ENG_TX;
          end
        end
        ENG_TX: begin
          if (drv_i) sda_oe_q <= (slot_q == ACK_SLOT) ? 1'b0 : ~sh_q[BYTE_W-1];
          if (smp_i) bit_q <= sda_i;
          if (done_i) begin
            if (slot_q == ACK_SLOT) begin
              if (addr_q && rw_q && !bit_q) begin
                st_q     <= ENG_RX;
                slot_q   <= '0;
                sda_oe_q <= 1'b0;
              end else begin
                st_q <= ENG_IDLE;
              end
            end else begin
              slot_q <= slot_q + 1'b1;
              sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ENG_RX: begin
          if (drv_i) begin
            if (slot_q == ACK_SLOT) begin
              sda_oe_q  <= ~ack_ctl_i;
              nack_tx_q <= ack_ctl_i;
            end else begin
              sda_oe_q <= 1'b0;
            end
          end
          if (smp_i && slot_q != ACK_SLOT) sh_q <= {sh_q[BYTE_W-2:0], sda_i};
          if (done_i) begin
            if (slot_q == ACK_SLOT) begin
              sda_oe_q <= 1'b0;
              slot_q   <= '0;
              if (nack_tx_q) st_q <= ENG_IDLE;
            end else begin
              slot_q <= slot_q + 1'b1;
            end
          end
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign run_o     = (st_q != ENG_IDLE);
  assign sda_oe_o  = sda_oe_q;
  assign tx_done_o = (st_q == ENG_TX) && done_i && (slot_q == ACK_SLOT);
  assign ack_lvl_o = bit_q;
  assign rx_load_o = (st_q == ENG_RX) && done_i && (slot_q == LAST_DATA);
  assign rx_byte_o = sh_q;
endmodule

// File: rtl/i2c_bm_regs.sv
module i2c_bm_regs
  import i2c_bm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              addr_phase_i,
  input  logic              mode_i,
  input  logic              rd_en_i,
  input  logic [FLAG_N-1:0] clr_i,
  input  logic              busy_i,
  input  logic              tx_done_i,
  input  logic              ack_lvl_i,
  input  logic              rx_load_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              start_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              addr_o,
  output logic              rw_o,
  output logic              hold_o,
  output logic              full_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [FLAG_N-1:0] flags_o
);
  logic [BYTE_W-1:0] buf_q;
  logic              full_q, hold_q, accept, take_rx;
  logic [FLAG_N-1:0] ld, val, flag_q;

  assign accept  = wr_en_i & ~busy_i;
  assign take_rx = rx_load_i & (~full_q | rd_en_i);

  assign start_o = accept;
  assign byte_o  = addr_phase_i ? {wdata_i[BYTE_W-2:0], mode_i} : wdata_i;
  assign addr_o  = addr_phase_i;
  assign rw_o    = mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (accept) begin
        buf_q  <= wdata_i;
        hold_q <= 1'b1;
      end
      if (take_rx) begin
        buf_q  <= rx_byte_i;
        full_q <= 1'b1;
      end else if (rd_en_i) begin
        full_q <= 1'b0;
      end
    end
  end

  always_comb begin
    ld            = '0;
    val           = '0;
    ld[FLG_TX]    = tx_done_i;
    val[FLG_TX]   = 1'b1;
    ld[FLG_RX]    = rx_load_i;
    val[FLG_RX]   = 1'b1;
    ld[FLG_NACK]  = tx_done_i;
    val[FLG_NACK] = ack_lvl_i;
    ld[FLG_OVR]   = rx_load_i & full_q & ~rd_en_i;
    val[FLG_OVR]  = 1'b1;
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    flag_q[i] <= 1'b0;
      else if (ld[i]) flag_q[i] <= val[i];
      else            flag_q[i] <= flag_q[i] & ~clr_i[i];
    end
  end

  assign hold_o  = hold_q;
  assign full_o  = full_q;
  assign rdata_o = buf_q;
  assign flags_o = flag_q;
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int HALF_CYC = 250
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  input  logic       addr_phase_i,
  input  logic       mode_i,
  input  logic       ack_ctl_i,
  input  logic       rd_en_i,
  input  logic [3:0] clr_i,
  input  logic       sda_i,
  output logic [7:0] rdata_o,
  output logic       busy_o,
  output logic       txdone_o,
  output logic       rxdone_o,
  output logic       nack_o,
  output logic       ovr_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  logic              run_w, hold_w, full_w;
  logic              drv_w, smp_w, done_w;
  logic              start_w, addr_w, rw_w;
  logic [BYTE_W-1:0] byte_w, rx_byte_w;
  logic              tx_done_w, ack_lvl_w, rx_load_w;
  logic [FLAG_N-1:0] flags_w;

  i2c_bm_sclgen #(.HALF_CYC(HALF_CYC)) u_scl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_w),
    .hold_i   (hold_w),
    .scl_oe_o (scl_oe_o),
    .drv_o    (drv_w),
    .smp_o    (smp_w),
    .done_o   (done_w)
  );

  i2c_bm_engine u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_w),
    .byte_i    (byte_w),
    .addr_i    (addr_w),
    .rw_i      (rw_w),
    .ack_ctl_i (ack_ctl_i),
    .sda_i     (sda_i),
    .drv_i     (drv_w),
    .smp_i     (smp_w),
    .done_i    (done_w),
    .run_o     (run_w),
    .sda_oe_o  (sda_oe_o),
    .tx_done_o (tx_done_w),
    .ack_lvl_o (ack_lvl_w),
    .rx_load_o (rx_load_w),
    .rx_byte_o (rx_byte_w)
  );

  i2c_bm_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wdata_i      (wdata_i),
    .addr_phase_i (addr_phase_i),
    .mode_i       (mode_i),
    .rd_en_i      (rd_en_i),
    .clr_i        (clr_i),
    .busy_i       (run_w),
    .tx_done_i    (tx_done_w),
    .ack_lvl_i    (ack_lvl_w),
    .rx_load_i    (rx_load_w),
    .rx_byte_i    (rx_byte_w),
    .start_o      (start_w),
    .byte_o       (byte_w),
    .addr_o       (addr_w),
    .rw_o         (rw_w),
    .hold_o       (hold_w),
    .full_o       (full_w),
    .rdata_o      (rdata_o),
    .flags_o      (flags_w)
  );

  assign busy_o   = run_w;
  assign txdone_o = flags_w[FLG_TX];
  assign rxdone_o = flags_w[FLG_RX];
  assign nack_o   = flags_w[FLG_NACK];
  assign ovr_o    = flags_w[FLG_OVR];
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic [7:0] rdata_o,
  input logic       busy_o,
  input logic       txdone_o,
  input logic       rxdone_o,
  input logic       nack_o,
  input logic       ovr_o,
  input logic       scl_oe_o,
  input logic       sda_oe_o,
  input logic       tx_evt_i,
  input logic       ack_lvl_i,
  input logic       rx_evt_i,
  input logic       full_i,
  input logic [7:0] rx_byte_i
);
  p_sda_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_o && $past(!scl_oe_o)) |-> $stable(sda_oe_o));

  p_busy_after_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && wr_en_i) |=> busy_o);

  p_write_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_en_i && !rx_evt_i) |=> (rdata_o == $past(rdata_o)));

  p_tx_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_evt_i |=> (txdone_o && (nack_o == $past(ack_lvl_i))));

  p_scl_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(busy_o)) |-> scl_oe_o);

  p_rx_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_evt_i |=> rxdone_o);

  p_ovr_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_evt_i && full_i && !rd_en_i) |=> (ovr_o && (rdata_o == $past(rdata_o))));

  p_rd_same_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_evt_i && rd_en_i) |=> (rdata_o == $past(rx_byte_i)));
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .rdata_o   (rdata_o),
  .busy_o    (busy_o),
  .txdone_o  (txdone_o),
  .rxdone_o  (rxdone_o),
  .nack_o    (nack_o),
  .ovr_o     (ovr_o),
  .scl_oe_o  (scl_oe_o),
  .sda_oe_o  (sda_oe_o),
  .tx_evt_i  (tx_done_w),
  .ack_lvl_i (ack_lvl_w),
  .rx_evt_i  (rx_load_w),
  .full_i    (full_w),
  .rx_byte_i (rx_byte_w)
);

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, addr_phase = 1'b0, mode = 1'b0, ack_ctl = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [3:0] clr = '0;
  logic [7:0] rdata;
  logic       busy, txdone, rxdone, nack, ovr, scl_oe, sda_oe;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  // open-drain lines with pull-ups and a slave target
  logic s_drive = 1'b0;
  wire  scl_line = ~scl_oe;
  wire  sda_line = ~(sda_oe | s_drive);

  i2c_byte_master #(.HALF_CYC(HALF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wdata_i(wdata),
    .addr_phase_i(addr_phase), .mode_i(mode), .ack_ctl_i(ack_ctl),
    .rd_en_i(rd_en), .clr_i(clr), .sda_i(sda_line), .rdata_o(rdata),
    .busy_o(busy), .txdone_o(txdone), .rxdone_o(rxdone), .nack_o(nack),
    .ovr_o(ovr), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  int         s_bit = 0, s_byte = 0;
  logic [7:0] s_sh = '0, s_got = '0;
  logic       s_ack_seen = 1'b1, s_rw = 1'b0, s_ack = 1'b1;
  logic [7:0] s_data [3];

  always @(posedge scl_line) begin
    if (s_bit < 8) begin
      s_sh  = {s_sh[6:0], sda_line};
      s_got = s_sh;
      s_bit++;
    end else begin
      s_ack_seen = sda_line;
      s_bit = 0;
      s_byte++;
    end
  end

  always @(negedge scl_line) begin
    if (s_byte == 0 || !s_rw) s_drive = (s_bit == 8) && s_ack;
    else if (s_bit < 8)       s_drive = ~s_data[(s_byte - 1) % 3][7 - s_bit];
    else                      s_drive = 1'b0;
  end

  // SCL edge and phase-length monitor
  int   rises = 0, hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
  logic scl_prev = 1'b1;
  always @(posedge clk) begin
    if (scl_line) begin
      if (!scl_prev) begin
        last_lo = lo_run;
        lo_run  = 0;
        rises++;
      end
      hi_run++;
    end else begin
      if (scl_prev) begin
        last_hi = hi_run;
        hi_run  = 0;
      end
      lo_run++;
    end
    scl_prev = scl_line;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic write_buf(input logic [7:0] d, input logic is_addr, input logic m);
    @(negedge clk);
    wdata = d; addr_phase = is_addr; mode = m; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr_phase = 1'b0;
  endtask

  task automatic clear_flags(input logic [3:0] m);
    @(negedge clk); clr = m;
    @(negedge clk); clr = '0;
  endtask

  task automatic wait_rise(input int n);
    while (rises < n) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic slave_reset(input logic rw, input logic ack);
    s_bit = 0; s_byte = 0; s_rw = rw; s_ack = ack; s_drive = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1 scl_oe", int'(scl_oe), 0);
    check("R1 sda_oe", int'(sda_oe), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 flags", int'({ovr, nack, rxdone, txdone}), 0);
    check("R1 rdata", int'(rdata), 0);
  endtask

  task automatic t_addr_write();
    slave_reset(1'b0, 1'b1);
    write_buf(8'h5A, 1'b1, 1'b0);
    check("R3 busy after write", int'(busy), 1);
    write_buf(8'hFF, 1'b0, 1'b0);
    check("R3 write ignored while busy", int'(rdata), 8'h5A);
    wait_idle();
    @(negedge clk);
    check("R2 address byte on bus", int'(s_got), 8'hB4);
    check("R5 txdone", int'(txdone), 1);
    check("R5 nack level", int'(nack), 0);
    check("R5 scl held low", int'(scl_oe), 1);
    check("R12 scl high length", last_hi, HALF);
    check("R12 scl low length", last_lo, HALF);
    clear_flags(4'hF);
  endtask

  task automatic t_tx_data();
    s_ack = 1'b1;
    write_buf(8'hC3, 1'b0, 1'b0);
    wait_idle();
    @(negedge clk);
    check("R4 data byte on bus", int'(s_got), 8'hC3);
    check("R5 ack sampled", int'(nack), 0);
    clear_flags(4'hF);
    s_ack = 1'b0;
    write_buf(8'h81, 1'b0, 1'b0);
    wait_idle();
    @(negedge clk);
    check("R4 data byte on bus", int'(s_got), 8'h81);
    check("R5 nack sampled", int'(nack), 1);
    check("R5 txdone", int'(txdone), 1);
    clear_flags(4'hF);
    check("R11 flags cleared", int'({ovr, nack, rxdone, txdone}), 0);
  endtask

  task automatic t_addr_nack_read();
    int r;
    slave_reset(1'b1, 1'b0);
    write_buf(8'h21, 1'b1, 1'b1);
    wait_idle();
    @(negedge clk);
    check("R6 nack", int'(nack), 1);
    check("R6 txdone", int'(txdone), 1);
    r = rises;
    repeat (40) @(negedge clk);
    check("R6 no further clocks", rises, r);
    check("R6 no receive", int'(rxdone), 0);
    check("R6 busy clear", int'(busy), 0);
    clear_flags(4'hF);
  endtask

  task automatic t_receive();
    int base;
    slave_reset(1'b1, 1'b1);
    s_data[0] = 8'hA5; s_data[1] = 8'h3C; s_data[2] = 8'h96;
    ack_ctl = 1'b0;
    base = rises;
    write_buf(8'h44, 1'b1, 1'b1);
    while (!txdone) @(negedge clk);
    check("R7 busy stays in receive", int'(busy), 1);
    wait_rise(base + 12);
    check("R7 sda released in data bits", int'(sda_oe), 0);
    while (!rxdone) @(negedge clk);
    check("R8 first byte", int'(rdata), 8'hA5);
    check("R9 no overrun yet", int'(ovr), 0);
    clear_flags(4'b0010);
    wait_rise(base + 18);
    check("R8 master ack driven", int'(s_ack_seen), 0);
    while (!rxdone) @(negedge clk);
    check("R9 overrun set", int'(ovr), 1);
    check("R9 old byte kept", int'(rdata), 8'hA5);
    clear_flags(4'b1010);
    ack_ctl = 1'b1;
    // read lands on the load cycle of the third byte
    wait_rise(base + 35);
    repeat (HALF - 2) @(posedge clk);
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    check("R10 new byte loaded", int'(rdata), 8'h96);
    check("R10 no overrun", int'(ovr), 0);
    check("R8 rxdone", int'(rxdone), 1);
    wait_idle();
    @(negedge clk);
    check("R8 nack sent", int'(s_ack_seen), 1);
    check("R8 busy clear after nack", int'(busy), 0);
    ack_ctl = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_addr_write();
    t_tx_data();
    t_addr_nack_read();
    t_receive();
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule